// File: doc/BRIEF.md
# Colour LCD Controller Register Interface

This block is the software-visible register file of a colour LCD controller. A processor reaches it over a simple 32-bit bus. The bus carries a word index, a write strobe and a read strobe. The block stores four timing words, the frame base addresses for the upper and lower panels, and a control word. It also keeps a small interrupt set made of an enable mask, a raw status register and a write-one-to-clear port. It returns a fixed eight-byte identification sequence near the top of its 4 KB window.

The block decodes the stored words into ready-to-use signals for the display pipeline:
- the number of active pixels per line;
- the number of lines per panel;
- the pixel depth code;
- the two big-endian ordering flags;
- a single active flag, which needs both the enable bit and the power bit.

Palette-window accesses are not stored here. Writes pass straight through to an external palette store. Reads take the data that store returns. Panel timing generation, frame fetch and the sources of interrupt events all sit outside this block. The events arrive as one-cycle pulses on `irq_evt`.

Top module: `lcd_regif`

## Requirements
- R1: After reset, every stored register is zero. As a result, `px_per_line` is 16, `lines_per_panel` is 1, `lcd_active`, `irq_out`, `rd_err` and `pal_wr` are 0, and `bus_rdata` is 0.
- R2: A write at word 0, 1, 2, 3 (timing 0..3), 4 (upper base), 5 (lower base) or 7 (control) stores the full 32-bit word. A read of any of these words returns the stored word in `bus_rdata` in the cycle after the read strobe. Word 6 (mask) keeps only its low IRQ_W bits and reads back zero-extended.
- R3: `px_per_line` equals ((timing0 & 0xFC) + 4) * 4. This is 16 times (timing0[7:2] + 1). Timing0 bits [1:0] and the bits above bit 7 have no effect on it.
- R4: `lines_per_panel` equals timing1[9:0] + 1. Timing1 bits above bit 9 have no effect on it.
- R5: The control word is decoded as follows:
  - bit 0 is enable;
  - bits [3:1] drive `pix_depth`;
  - bit 9 drives `be_byte`;
  - bit 10 drives `be_pixel`;
  - bit 11 is power.
  `lcd_active` is 1 only when bit 0 and bit 11 are both 1.
- R6: Reads of word 11 return the upper base and reads of word 12 return the lower base. The `upper_base` and `lower_base` outputs follow words 4 and 5.
- R7: An `irq_evt` pulse on bit i sets raw status bit i, which reads at word 8. Word 9 reads raw status AND mask. `irq_out` is 1 while raw AND mask is nonzero. An event on a bit wins over a clear of that bit in the same cycle.
- R8: A write to word 10 clears every raw status bit whose bit in the written value is 1. Raw status bits whose written bit is 0 are unchanged.
- R9: Reads of words 1016 to 1023 return 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05 and 0xB1, in that order, in the low byte, with the upper bits zero.
- R10: Words 128 to 255 form the palette window:
  - a write there raises `pal_wr` in the same cycle, with `pal_idx` equal to the word minus 128 and `pal_wdata` equal to `bus_wdata`;
  - a read there returns `pal_rdata` as sampled at the read strobe;
  - `pal_wr` is never 1 outside a palette-window write.
- R11: Writes to words 8, 9, 11 and 12 change no state. Writes to the identification window also change no state.
- R12: A read of word 10, of words 13 to 127, or of words 256 to 1015 returns zero. It also raises `rd_err` for exactly one cycle, aligned with the returned data. Reads of mapped words leave `rd_err` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (10) | Word index within the 4 KB register window |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after `bus_rd` |
| rd_err | output | 1 | One-cycle flag for a read of an unmapped word |
| irq_evt | input | IRQ_W (5) | Interrupt event pulses, one per status bit |
| irq_out | output | 1 | Combined masked interrupt |
| px_per_line | output | 11 | Active pixels per line |
| lines_per_panel | output | 11 | Lines per panel |
| pix_depth | output | 3 | Pixel depth code |
| be_byte | output | 1 | Big-endian byte order flag |
| be_pixel | output | 1 | Big-endian pixel order within a byte |
| lcd_active | output | 1 | Enable and power both set |
| upper_base | output | DATA_W (32) | Upper panel frame base |
| lower_base | output | DATA_W (32) | Lower panel frame base |
| pal_wr | output | 1 | Palette write strobe |
| pal_idx | output | 7 | Palette word index |
| pal_wdata | output | DATA_W (32) | Palette write data |
| pal_rdata | input | DATA_W (32) | Palette read data from the palette store |

## Verification
The checker watches several behaviours on every cycle:
- the pixel-count and line-count decode after each timing write;
- the active flag after each control write;
- the interrupt raised by a masked event, including its priority over a clear;
- the full clear;
- the shape of the error pulse and the zero data returned with it;
- the confinement of `pal_wr` to palette-window writes.

Other behaviours only the directed scenarios can show:
- readback of every register and the current-address aliases;
- the exact identification byte order;
- palette round trips through an external store;
- partial clears;
- the proof that writes to read-only words leave the state untouched, which needs a write followed by a readback.

// File: rtl/lcdreg_pkg.sv
package lcdreg_pkg;

  typedef enum logic [1:0] {
    RG_CORE = 2'd0,
    RG_PAL  = 2'd1,
    RG_ID   = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  localparam int CORE_WORDS = 13;
  localparam int PAL_FIRST  = 128;
  localparam int PAL_WORDS  = 128;
  localparam int PAL_IDX_W  = $clog2(PAL_WORDS);
  localparam int ID_WORDS   = 8;
  localparam int ID_IDX_W   = $clog2(ID_WORDS);
  localparam int CNT_W      = 11;

  localparam logic [3:0] OFS_TIM0  = 4'd0;
  localparam logic [3:0] OFS_TIM1  = 4'd1;
  localparam logic [3:0] OFS_TIM2  = 4'd2;
  localparam logic [3:0] OFS_TIM3  = 4'd3;
  localparam logic [3:0] OFS_UBASE = 4'd4;
  localparam logic [3:0] OFS_LBASE = 4'd5;
  localparam logic [3:0] OFS_MASK  = 4'd6;
  localparam logic [3:0] OFS_CTRL  = 4'd7;
  localparam logic [3:0] OFS_RAW   = 4'd8;
  localparam logic [3:0] OFS_MSKD  = 4'd9;
  localparam logic [3:0] OFS_CLR   = 4'd10;
  localparam logic [3:0] OFS_UCUR  = 4'd11;
  localparam logic [3:0] OFS_LCUR  = 4'd12;

  // control word bit positions
  localparam int CB_EN    = 0;
  localparam int CB_DEPLO = 1;
  localparam int CB_BEBY  = 9;
  localparam int CB_BEPX  = 10;
  localparam int CB_PWR   = 11;

  // pixels per line: sixteen per step of the 6-bit field in timing0[7:2]
  function automatic logic [CNT_W-1:0] f_line_pixels(input logic [7:0] t0);
    return {({1'b0, t0[7:2]} + 7'd1), 4'b0000};
  endfunction

  // lines per panel: 10-bit field plus one
  function automatic logic [CNT_W-1:0] f_panel_lines(input logic [9:0] t1);
    return {1'b0, t1} + 11'd1;
  endfunction

  // identification byte sequence
  function automatic logic [7:0] f_ident_byte(input logic [ID_IDX_W-1:0] k);
    case (k)
      3'd0:    return 8'h10;
      3'd1:    return 8'h11;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcdreg_decode.sv
module lcdreg_decode
  import lcdreg_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0]    addr,
  output region_e              region,
  output logic [3:0]           core_ofs,
  output logic [PAL_IDX_W-1:0] pal_idx,
  output logic [ID_IDX_W-1:0]  id_idx,
  output logic                 core_rd_ok,
  output logic                 core_wr_ok
);

  localparam int WIN_WORDS = 1 << ADDR_W;
  localparam int ID_FIRST  = WIN_WORDS - ID_WORDS;

  always_comb begin
    if (addr < ADDR_W'(CORE_WORDS))
      region = RG_CORE;
    else if (addr >= ADDR_W'(PAL_FIRST) && addr < ADDR_W'(PAL_FIRST + PAL_WORDS))
      region = RG_PAL;
    else if (addr >= ADDR_W'(ID_FIRST))
      region = RG_ID;
    else
      region = RG_NONE;
  end

  assign core_ofs = addr[3:0];
  assign pal_idx  = addr[PAL_IDX_W-1:0];
  assign id_idx   = addr[ID_IDX_W-1:0];

  // the clear word is write-only; status and current-address words are read-only
  assign core_rd_ok = (region == RG_CORE) && (core_ofs != OFS_CLR);
  assign core_wr_ok = (region == RG_CORE) &&
                      ((core_ofs <= OFS_CTRL) || (core_ofs == OFS_CLR));

endmodule

// File: rtl/lcdreg_irq.sv
module lcdreg_irq #(
  parameter int IRQ_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wd,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_wd,
  input  logic [IRQ_W-1:0] evt,
  output logic [IRQ_W-1:0] mask_q,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] masked,
  output logic             irq_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_wd;
  end

  for (genvar b = 0; b < IRQ_W; b++) begin : g_stat
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      bit_q <= 1'b0;
      else if (evt[b])                 bit_q <= 1'b1;  // set beats clear
      else if (clr_we && clr_wd[b])    bit_q <= 1'b0;
    end
    assign raw_q[b] = bit_q;
  end

  assign masked  = raw_q & mask_q;
  assign irq_out = |masked;

endmodule

// File: rtl/lcdreg_rdmux.sv
module lcdreg_rdmux
  import lcdreg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  region_e             region,
  input  logic [3:0]          core_ofs,
  input  logic                core_rd_ok,
  input  logic [ID_IDX_W-1:0] id_idx,
  input  logic [DATA_W-1:0]   tim0,
  input  logic [DATA_W-1:0]   tim1,
  input  logic [DATA_W-1:0]   tim2,
  input  logic [DATA_W-1:0]   tim3,
  input  logic [DATA_W-1:0]   ubase,
  input  logic [DATA_W-1:0]   lbase,
  input  logic [DATA_W-1:0]   ctrl,
  input  logic [IRQ_W-1:0]    mask,
  input  logic [IRQ_W-1:0]    raw,
  input  logic [IRQ_W-1:0]    masked,
  input  logic [DATA_W-1:0]   pal_rdata,
  output logic [DATA_W-1:0]   rdata,
  output logic                rd_err
);

  logic [DATA_W-1:0] core_val;
  logic [DATA_W-1:0] sel_val;
  logic              hit;

  always_comb begin
    case (core_ofs)
      OFS_TIM0:  core_val = tim0;
      OFS_TIM1:  core_val = tim1;
      OFS_TIM2:  core_val = tim2;
      OFS_TIM3:  core_val = tim3;
      OFS_UBASE: core_val = ubase;
      OFS_LBASE: core_val = lbase;
      OFS_MASK:  core_val = DATA_W'(mask);
      OFS_CTRL:  core_val = ctrl;
      OFS_RAW:   core_val = DATA_W'(raw);
      OFS_MSKD:  core_val = DATA_W'(masked);
      OFS_UCUR:  core_val = ubase;
      OFS_LCUR:  core_val = lbase;
      default:   core_val = '0;
    endcase
  end

  always_comb begin
    hit     = 1'b1;
    sel_val = '0;
    case (region)
      RG_CORE: begin
        hit     = core_rd_ok;
        sel_val = core_rd_ok ? core_val : '0;
      end
      RG_PAL:  sel_val = pal_rdata;
      RG_ID:   sel_val = DATA_W'(f_ident_byte(id_idx));
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rd_err <= 1'b0;
    end else begin
      rd_err <= rd && !hit;
      if (rd) rdata <= sel_val;
    end
  end

endmodule

// File: rtl/lcd_regif.sv
module lcd_regif
  import lcdreg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 rd_err,
  input  logic [IRQ_W-1:0]     irq_evt,
  output logic                 irq_out,
  output logic [CNT_W-1:0]     px_per_line,
  output logic [CNT_W-1:0]     lines_per_panel,
  output logic [2:0]           pix_depth,
  output logic                 be_byte,
  output logic                 be_pixel,
  output logic                 lcd_active,
  output logic [DATA_W-1:0]    upper_base,
  output logic [DATA_W-1:0]    lower_base,
  output logic                 pal_wr,
  output logic [PAL_IDX_W-1:0] pal_idx,
  output logic [DATA_W-1:0]    pal_wdata,
  input  logic [DATA_W-1:0]    pal_rdata
);

  region_e             region;
  logic [3:0]          core_ofs;
  logic [ID_IDX_W-1:0] id_idx;
  logic                core_rd_ok;
  logic                core_wr_ok;

  lcdreg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .region     (region),
    .core_ofs   (core_ofs),
    .pal_idx    (pal_idx),
    .id_idx     (id_idx),
    .core_rd_ok (core_rd_ok),
    .core_wr_ok (core_wr_ok)
  );

  // named write events
  logic wr_core, wr_tim0, wr_tim1, wr_tim2, wr_tim3;
  logic wr_ubase, wr_lbase, wr_mask, wr_ctrl, wr_clr;

  assign wr_core  = bus_wr && core_wr_ok;
  assign wr_tim0  = wr_core && (core_ofs == OFS_TIM0);
  assign wr_tim1  = wr_core && (core_ofs == OFS_TIM1);
  assign wr_tim2  = wr_core && (core_ofs == OFS_TIM2);
  assign wr_tim3  = wr_core && (core_ofs == OFS_TIM3);
  assign wr_ubase = wr_core && (core_ofs == OFS_UBASE);
  assign wr_lbase = wr_core && (core_ofs == OFS_LBASE);
  assign wr_mask  = wr_core && (core_ofs == OFS_MASK);
  assign wr_ctrl  = wr_core && (core_ofs == OFS_CTRL);
  assign wr_clr   = wr_core && (core_ofs == OFS_CLR);

  logic [DATA_W-1:0] tim0_q, tim1_q, tim2_q, tim3_q;
  logic [DATA_W-1:0] ubase_q, lbase_q, ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim0_q  <= '0;
      tim1_q  <= '0;
      tim2_q  <= '0;
      tim3_q  <= '0;
      ubase_q <= '0;
      lbase_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (wr_tim0)  tim0_q  <= bus_wdata;
      if (wr_tim1)  tim1_q  <= bus_wdata;
      if (wr_tim2)  tim2_q  <= bus_wdata;
      if (wr_tim3)  tim3_q  <= bus_wdata;
      if (wr_ubase) ubase_q <= bus_wdata;
      if (wr_lbase) lbase_q <= bus_wdata;
      if (wr_ctrl)  ctrl_q  <= bus_wdata;
    end
  end

  logic [IRQ_W-1:0] mask_q, raw_q, masked;

  lcdreg_irq #(.IRQ_W(IRQ_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .mask_we (wr_mask),
    .mask_wd (bus_wdata[IRQ_W-1:0]),
    .clr_we  (wr_clr),
    .clr_wd  (bus_wdata[IRQ_W-1:0]),
    .evt     (irq_evt),
    .mask_q  (mask_q),
    .raw_q   (raw_q),
    .masked  (masked),
    .irq_out (irq_out)
  );

  lcdreg_rdmux #(.DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (bus_rd),
    .region     (region),
    .core_ofs   (core_ofs),
    .core_rd_ok (core_rd_ok),
    .id_idx     (id_idx),
    .tim0       (tim0_q),
    .tim1       (tim1_q),
    .tim2       (tim2_q),
    .tim3       (tim3_q),
    .ubase      (ubase_q),
    .lbase      (lbase_q),
    .ctrl       (ctrl_q),
    .mask       (mask_q),
    .raw        (raw_q),
    .masked     (masked),
    .pal_rdata  (pal_rdata),
    .rdata      (bus_rdata),
    .rd_err     (rd_err)
  );

  // palette pass-through
  assign pal_wr    = bus_wr && (region == RG_PAL);
  assign pal_wdata = bus_wdata;

  // decoded configuration
  assign px_per_line     = f_line_pixels(tim0_q[7:0]);
  assign lines_per_panel = f_panel_lines(tim1_q[9:0]);
  assign pix_depth       = ctrl_q[CB_DEPLO +: 3];
  assign be_byte         = ctrl_q[CB_BEBY];
  assign be_pixel        = ctrl_q[CB_BEPX];
  assign lcd_active      = ctrl_q[CB_EN] && ctrl_q[CB_PWR];
  assign upper_base      = ubase_q;
  assign lower_base      = lbase_q;

endmodule

// File: rtl/lcd_regif_chk.sv
module lcd_regif_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              rd_err,
  input logic [IRQ_W-1:0]  irq_evt,
  input logic              irq_out,
  input logic [IRQ_W-1:0]  mask_q,
  input logic              pal_wr,
  input logic [10:0]       px_per_line,
  input logic [10:0]       lines_per_panel,
  input logic              lcd_active
);

  p_pixels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(0)) |=>
      px_per_line == {($past({1'b0, bus_wdata[7:2]}) + 7'd1), 4'b0000});

  p_lines_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(1)) |=>
      lines_per_panel == ({1'b0, $past(bus_wdata[9:0])} + 11'd1));

  p_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(7)) |=>
      lcd_active == ($past(bus_wdata[0]) && $past(bus_wdata[11])));

  p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(irq_evt & mask_q)) && !(bus_wr && bus_addr == ADDR_W'(6))) |=> irq_out);

  p_full_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_W'(10) && (&bus_wdata[IRQ_W-1:0]) && irq_evt == '0)
      |=> !irq_out);

  p_pal_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pal_wr |-> (bus_wr && bus_addr >= ADDR_W'(128) && bus_addr < ADDR_W'(256)));

  p_err_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> (bus_rdata == '0));

  p_err_follows_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> $past(bus_rd));

endmodule

bind lcd_regif lcd_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_addr        (bus_addr),
  .bus_wr          (bus_wr),
  .bus_rd          (bus_rd),
  .bus_wdata       (bus_wdata),
  .bus_rdata       (bus_rdata),
  .rd_err          (rd_err),
  .irq_evt         (irq_evt),
  .irq_out         (irq_out),
  .mask_q          (mask_q),
  .pal_wr          (pal_wr),
  .px_per_line     (px_per_line),
  .lines_per_panel (lines_per_panel),
  .lcd_active      (lcd_active)
);

// File: tb/lcd_regif_test.sv
module lcd_regif_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rd_err;
  logic [4:0]  irq_evt = '0;
  logic        irq_out;
  logic [10:0] px_per_line, lines_per_panel;
  logic [2:0]  pix_depth;
  logic        be_byte, be_pixel, lcd_active;
  logic [31:0] upper_base, lower_base;
  logic        pal_wr;
  logic [6:0]  pal_idx;
  logic [31:0] pal_wdata, pal_rdata;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  lcd_regif uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_err(rd_err),
    .irq_evt(irq_evt), .irq_out(irq_out), .px_per_line(px_per_line),
    .lines_per_panel(lines_per_panel), .pix_depth(pix_depth), .be_byte(be_byte),
    .be_pixel(be_pixel), .lcd_active(lcd_active), .upper_base(upper_base),
    .lower_base(lower_base), .pal_wr(pal_wr), .pal_idx(pal_idx),
    .pal_wdata(pal_wdata), .pal_rdata(pal_rdata)
  );

  // external palette store model
  logic [31:0] pal_mem [128];
  initial for (int i = 0; i < 128; i++) pal_mem[i] = 32'h0;
  always @(posedge clk) if (pal_wr) pal_mem[pal_idx] <= pal_wdata;
  assign pal_rdata = pal_mem[pal_idx];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input int a, input logic [31:0] d);
    @(negedge clk); bus_addr = 10'(a); bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic brd(input int a, output logic [31:0] d, output logic e);
    @(negedge clk); bus_addr = 10'(a); bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata; e = rd_err;
  endtask

  task automatic pulse_evt(input logic [4:0] v);
    @(negedge clk); irq_evt = v;
    @(negedge clk); irq_evt = '0;
  endtask

  task automatic t_reset_r1();
    check("R1 px_per_line", 32'(px_per_line), 32'd16);
    check("R1 lines", 32'(lines_per_panel), 32'd1);
    check("R1 active", 32'(lcd_active), 32'd0);
    check("R1 irq", 32'(irq_out), 32'd0);
    check("R1 rdata", bus_rdata, 32'd0);
    check("R1 rd_err", 32'(rd_err), 32'd0);
    check("R1 pal_wr", 32'(pal_wr), 32'd0);
  endtask

  task automatic t_readback_r2();
    logic [31:0] d; logic e;
    logic [31:0] vals [8];
    vals[0] = 32'hA5A5_1234; vals[1] = 32'h5A5A_4321; vals[2] = 32'hDEAD_BEEF;
    vals[3] = 32'h0123_4567; vals[4] = 32'h8000_1000; vals[5] = 32'h0004_2000;
    vals[6] = 32'hFFFF_FFEA; vals[7] = 32'h0000_0000;
    for (int a = 0; a < 8; a++) if (a != 7) bwr(a, vals[a]);
    for (int a = 0; a < 7; a++) begin
      brd(a, d, e);
      if (a == 6) check("R2 mask readback", d, 32'h0000_000A);
      else        check("R2 readback", d, vals[a]);
    end
    bwr(7, 32'hFFFF_F000);
    brd(7, d, e);
    check("R2 ctrl readback", d, 32'hFFFF_F000);
    check("R6 upper_base", upper_base, 32'h8000_1000);
    check("R6 lower_base", lower_base, 32'h0004_2000);
  endtask

  task automatic t_geometry_r3_r4();
    logic [31:0] t0v [4];
    logic [31:0] t1v [3];
    t0v[0] = 32'h0000_00FC; t0v[1] = 32'h0000_0044; t0v[2] = 32'hFFFF_FF03; t0v[3] = 32'h0000_004F;
    t1v[0] = 32'h0000_03FF; t1v[1] = 32'hFFFF_FCEF; t1v[2] = 32'h0000_0000;
    foreach (t0v[i]) begin
      bwr(0, t0v[i]);
      check("R3 px_per_line", 32'(px_per_line), ((t0v[i] & 32'hFC) + 32'd4) * 32'd4);
    end
    foreach (t1v[i]) begin
      bwr(1, t1v[i]);
      check("R4 lines_per_panel", 32'(lines_per_panel), (t1v[i] & 32'h3FF) + 32'd1);
    end
  endtask

  task automatic t_control_r5();
    bwr(7, 32'h0000_0E0B);
    check("R5 active both", 32'(lcd_active), 32'd1);
    check("R5 depth", 32'(pix_depth), 32'd5);
    check("R5 be_byte", 32'(be_byte), 32'd1);
    check("R5 be_pixel", 32'(be_pixel), 32'd1);
    bwr(7, 32'h0000_0001);
    check("R5 enable only", 32'(lcd_active), 32'd0);
    check("R5 be_byte off", 32'(be_byte), 32'd0);
    bwr(7, 32'h0000_0800);
    check("R5 power only", 32'(lcd_active), 32'd0);
    bwr(7, 32'h0000_0204);
    check("R5 depth 2", 32'(pix_depth), 32'd2);
    check("R5 be_byte only", {30'd0, be_byte, be_pixel}, 32'd2);
  endtask

  task automatic t_current_r6();
    logic [31:0] d; logic e;
    bwr(4, 32'h1234_5678);
    bwr(5, 32'h9ABC_DEF0);
    brd(11, d, e); check("R6 upper current", d, 32'h1234_5678);
    brd(12, d, e); check("R6 lower current", d, 32'h9ABC_DEF0);
  endtask

  task automatic t_irq_r7_r8();
    logic [31:0] d; logic e;
    bwr(6, 32'h0000_0005);
    pulse_evt(5'h06);
    brd(8, d, e); check("R7 raw", d, 32'h6);
    brd(9, d, e); check("R7 masked", d, 32'h4);
    check("R7 irq_out", 32'(irq_out), 32'd1);
    bwr(10, 32'h0000_0004);
    brd(8, d, e); check("R8 partial clear raw", d, 32'h2);
    check("R8 irq low", 32'(irq_out), 32'd0);
    // simultaneous clear and event on bit 1
    @(negedge clk); bus_addr = 10'd10; bus_wr = 1'b1; bus_wdata = 32'h2; irq_evt = 5'h02;
    @(negedge clk); bus_wr = 1'b0; irq_evt = '0;
    brd(8, d, e); check("R7 set beats clear", d, 32'h2);
    bwr(10, 32'hFFFF_FFFF);
    brd(8, d, e); check("R8 full clear", d, 32'h0);
  endtask

  task automatic t_ident_r9();
    logic [31:0] d; logic e;
    logic [7:0] idb [8];
    idb[0] = 8'h10; idb[1] = 8'h11; idb[2] = 8'h04; idb[3] = 8'h00;
    idb[4] = 8'h0D; idb[5] = 8'hF0; idb[6] = 8'h05; idb[7] = 8'hB1;
    for (int k = 0; k < 8; k++) begin
      brd(1016 + k, d, e);
      check("R9 ident", d, {24'd0, idb[k]});
      check("R9 no err", 32'(e), 32'd0);
    end
  endtask

  task automatic t_palette_r10();
    logic [31:0] d; logic e;
    @(negedge clk); bus_addr = 10'd133; bus_wr = 1'b1; bus_wdata = 32'hCAFE_0133;
    #1;
    check("R10 pal_wr", 32'(pal_wr), 32'd1);
    check("R10 pal_idx", 32'(pal_idx), 32'd5);
    check("R10 pal_wdata", pal_wdata, 32'hCAFE_0133);
    @(negedge clk); bus_wr = 1'b0;
    bwr(255, 32'h0000_7FFF);
    brd(133, d, e); check("R10 pal read", d, 32'hCAFE_0133);
    brd(255, d, e); check("R10 pal read top", d, 32'h0000_7FFF);
    @(negedge clk); bus_addr = 10'd4; bus_wr = 1'b1; bus_wdata = 32'h1234_5678;
    #1; check("R10 no pal_wr on core", 32'(pal_wr), 32'd0);
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic t_readonly_r11();
    logic [31:0] d; logic e;
    bwr(6, 32'h1F);
    bwr(8, 32'hFFFF_FFFF);
    brd(8, d, e); check("R11 raw unchanged", d, 32'h0);
    check("R11 irq unchanged", 32'(irq_out), 32'd0);
    bwr(9, 32'hFFFF_FFFF);
    brd(9, d, e); check("R11 masked unchanged", d, 32'h0);
    bwr(11, 32'h0BAD_0BAD);
    bwr(12, 32'h0BAD_0BAD);
    brd(11, d, e); check("R11 upper current unchanged", d, 32'h1234_5678);
    check("R11 upper_base unchanged", upper_base, 32'h1234_5678);
    brd(12, d, e); check("R11 lower current unchanged", d, 32'h9ABC_DEF0);
    bwr(1016, 32'h0000_0077);
    brd(1016, d, e); check("R11 ident unchanged", d, 32'h10);
  endtask

  task automatic t_unmapped_r12();
    logic [31:0] d; logic e;
    int addrs [4];
    addrs[0] = 10; addrs[1] = 13; addrs[2] = 127; addrs[3] = 1015;
    foreach (addrs[i]) begin
      brd(addrs[i], d, e);
      check("R12 data zero", d, 32'h0);
      check("R12 err", 32'(e), 32'd1);
      @(negedge clk);
      check("R12 err one cycle", 32'(rd_err), 32'd0);
    end
    brd(256, d, e); check("R12 err above palette", 32'(e), 32'd1);
    brd(0, d, e); check("R12 mapped no err", 32'(e), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_r1();
    t_readback_r2();
    t_geometry_r3_r4();
    t_control_r5();
    t_current_r6();
    t_irq_r7_r8();
    t_ident_r9();
    t_palette_r10();
    t_readonly_r11();
    t_unmapped_r12();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule